// File: doc/BRIEF.md
# Switch-and-Register Peripheral on an APB Bus

This block is a completer on an APB bus. It offers a software-visible view of two external switch levels and one 32-bit general storage word. A requester reads a switch by reading its word slot and gets the level in bit 0. Any other word slot reads back the storage word, and a write to such a slot replaces it. Only the low address byte takes part in decoding, so the block can sit in any window of the system map without changes.

Each switch input is sampled into the clock domain by a two-stage flop chain before it can be read. Read data is captured into a register at the end of the setup cycle, so the value is stable for the whole access cycle. The block never inserts wait states and never reports an error. The reset is synchronous and active high, and it clears the storage word, the read-data register and the synchroniser stages.

Top module: `apb_switch_reg`

## Requirements
- R1: After reset the read-data output is zero, and a read of the storage slot returns zero.
- R2: A read at byte offset 0x00 returns the synchronised level of switch A in bit 0, with bits 31..1 zero.
- R3: A read at byte offset 0x04 returns the synchronised level of switch B in bit 0, with bits 31..1 zero.
- R4: A write in the access cycle (select, enable and write all high) to offset 0x08 loads the write data into the storage word, and a later read of 0x08 returns it.
- R5: The storage word does not change unless select, enable and write are all high in the same cycle. A setup-only cycle, or enable and write without select, has no effect.
- R6: Writes to the switch offsets 0x00 and 0x04 are accepted and ignored. The storage word keeps its value, and switch reads are unaffected.
- R7: Address bits above bit 7 are ignored. Every word offset other than 0x00 and 0x04 (for example 0xF0) aliases the storage word for both reads and writes.
- R8: The ready output is high and the error output is low on every access cycle.
- R9: A switch change is not seen by a read whose setup cycle begins in the same cycle as the change. It is seen by a read whose setup cycle begins two clocks after the change.
- R10: A read of the storage slot that directly follows a write to it, with no idle cycle between, returns the newly written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Completer select |
| bus_en | input | 1 | High in the access cycle of a transfer |
| bus_wr | input | 1 | Direction: 1 write, 0 read |
| bus_addr | input | 32 | Byte address; only bits 7..0 are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid in the access cycle |
| bus_ready | output | 1 | Transfer complete, always high |
| bus_err | output | 1 | Error response, always low |
| sw_in | input | 2 | Asynchronous switch levels; bit 0 is A, bit 1 is B |

## Verification
A corrupted storage word can only be seen through a read, so each write is followed by a readback in the very next transfer, and stray write-like cycles are followed by one as well. A fault in the switch path shows as a wrong bit 0 or a nonzero upper bit in the access cycle of a switch read. A wrong synchroniser depth shows as a switch change that appears one read too early or too late. Read-data capture faults appear at once, in the access cycle of the affected read.

// File: rtl/apb_sw_pkg.sv
package apb_sw_pkg;
  typedef enum logic [0:0] {
    HIT_SWITCH = 1'b0,
    HIT_STORE  = 1'b1
  } hit_e;
endpackage

// File: rtl/apb_sw_sync.sv
module apb_sw_sync #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic stable_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= async_in[g];
        stable_q <= meta_q;
      end
    end
    assign sync_out[g] = stable_q;
  end
endmodule

// File: rtl/apb_sw_store.sv
module apb_sw_store #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= wdata;
  end

  // R4: a qualified write lands on the next edge
  a_r4_load_takes: assert property (@(posedge clk) disable iff (rst)
    load |=> (q == $past(wdata)));
  // R5: nothing else moves the word
  a_r5_hold_otherwise: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));
endmodule

// File: rtl/apb_sw_rdmux.sv
module apb_sw_rdmux
  import apb_sw_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NUM_SW = 2,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  hit_e              kind,
  input  logic [IDX_W-1:0]  idx,
  input  logic [NUM_SW-1:0] sw,
  input  logic [DATA_W-1:0] store_q,
  output logic [DATA_W-1:0] rdata
);
  logic              sw_bit;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    sw_bit = 1'b0;
    for (int k = 0; k < NUM_SW; k++) begin
      if (idx == IDX_W'(k)) sw_bit = sw[k];
    end
    rdata_d = (kind == HIT_SWITCH) ? DATA_W'(sw_bit) : store_q;
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata <= '0;
    else if (capture) rdata <= rdata_d;
  end

  // R2 and R3: a switch read never carries upper bits
  a_r2_switch_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (capture && kind == HIT_SWITCH) |=> (rdata[DATA_W-1:1] == '0));
  // R10: a storage read shows the word as it stood at capture
  a_r10_store_read: assert property (@(posedge clk) disable iff (rst)
    (capture && kind == HIT_STORE) |=> (rdata == $past(store_q)));
endmodule

// File: rtl/apb_switch_reg.sv
module apb_switch_reg
  import apb_sw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEC_W  = 8,
  parameter int NUM_SW = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              bus_err,
  input  logic [NUM_SW-1:0] sw_in
);
  localparam int IDX_W = DEC_W - 2;

  logic [IDX_W-1:0]  idx;
  hit_e              kind;
  logic              capture;
  logic              wr_fire;
  logic [NUM_SW-1:0] sw_sync;
  logic [DATA_W-1:0] store_q;
  logic              unused_addr;

  assign idx         = bus_addr[DEC_W-1:2];
  assign unused_addr = ^{bus_addr[ADDR_W-1:DEC_W], bus_addr[1:0]};
  assign kind        = (idx < IDX_W'(NUM_SW)) ? HIT_SWITCH : HIT_STORE;
  assign capture     = bus_sel & ~bus_en & ~bus_wr;
  assign wr_fire     = bus_sel & bus_en & bus_wr & (kind == HIT_STORE);
  assign bus_ready   = 1'b1;
  assign bus_err     = 1'b0;

  apb_sw_sync #(.N(NUM_SW)) sync_i (
    .clk(clk), .rst(rst), .async_in(sw_in), .sync_out(sw_sync)
  );

  apb_sw_store #(.DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst), .load(wr_fire), .wdata(bus_wdata), .q(store_q)
  );

  apb_sw_rdmux #(.DATA_W(DATA_W), .NUM_SW(NUM_SW), .IDX_W(IDX_W)) rdmux_i (
    .clk(clk), .rst(rst), .capture(capture), .kind(kind), .idx(idx),
    .sw(sw_sync), .store_q(store_q), .rdata(bus_rdata)
  );

  // R1: reset clears the word and the read path
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (store_q == '0 && bus_rdata == '0));
  // R6: writes aimed at a switch slot leave the word alone
  a_r6_switch_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_en && bus_wr && kind == HIT_SWITCH) |=> $stable(store_q));
endmodule

// File: tb/apb_switch_reg_tb.sv
module apb_switch_reg_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_en = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, bus_err;
  logic [1:0]  sw_in = 2'b00;

  int checks = 0;
  int fails  = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_switch_reg dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_en(bus_en), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .sw_in(sw_in)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  // Tasks start and end just after a rising edge; transfers chain back to back.
  task automatic write(logic [31:0] a, logic [31:0] d);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic read(logic [31:0] a, logic [31:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b0; bus_addr = a;
    @(posedge clk); #1;
    bus_en = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic idle(int n);
    bus_sel = 1'b0; bus_en = 1'b0; bus_wr = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  // Monitor: compare in the middle of each access cycle.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && bus_sel && bus_en) begin
        check("R8 ready", {31'b0, bus_ready}, 32'd1);
        check("R8 err", {31'b0, bus_err}, 32'd0);
        if (!bus_wr) begin
          if (exp_q.size() == 0) begin
            check("scoreboard underflow", 32'd1, 32'd0);
          end else begin
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
          end
        end
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    check("R1 rdata after reset", bus_rdata, 32'h0);
    @(posedge clk); #1;
    read(32'h08, 32'h0, "R1 store after reset");
    read(32'h00, 32'h0, "R2 switch A low");
    read(32'h04, 32'h0, "R3 switch B low");
    idle(1);

    sw_in = 2'b01; idle(3);
    read(32'h00, 32'h1, "R2 switch A high");
    read(32'h04, 32'h0, "R3 switch B low with A high");
    idle(1);
    sw_in = 2'b10; idle(3);
    read(32'h00, 32'h0, "R2 switch A low with B high");
    read(32'h04, 32'h1, "R3 switch B high");
    idle(1);

    write(32'h08, 32'hDEADBEEF);
    read(32'h08, 32'hDEADBEEF, "R4 R10 readback");
    write(32'h08, 32'hFFFFFFFF);
    read(32'h08, 32'hFFFFFFFF, "R10 all ones");
    write(32'h08, 32'hDEADBEEF);
    idle(1);

    write(32'h00, 32'h11111111);
    write(32'h04, 32'h22222222);
    read(32'h08, 32'hDEADBEEF, "R6 store kept");
    read(32'h04, 32'h1, "R6 switch B read unaffected");
    idle(1);

    // R5: setup-only write, then enable+write without select
    bus_sel = 1'b1; bus_en = 1'b0; bus_wr = 1'b1; bus_addr = 32'h08; bus_wdata = 32'h33333333;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_en = 1'b1; bus_wr = 1'b1; bus_wdata = 32'h44444444;
    @(posedge clk); #1;
    idle(1);
    read(32'h08, 32'hDEADBEEF, "R5 unqualified writes ignored");
    idle(1);

    write(32'hABCD_1208, 32'hA5A50F0F);
    read(32'hFFFF_FF08, 32'hA5A50F0F, "R7 upper bits ignored store");
    read(32'h1234_5604, 32'h1, "R7 upper bits ignored switch B");
    read(32'h0000_00F0, 32'hA5A50F0F, "R7 alias read");
    write(32'h0000_00FC, 32'h0BADF00D);
    read(32'h08, 32'h0BADF00D, "R7 alias write");
    idle(1);

    // R9: switch A rises together with a read setup
    sw_in = 2'b11;
    read(32'h00, 32'h0, "R9 change not yet visible");
    read(32'h00, 32'h1, "R9 change visible two clocks later");
    idle(3);

    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule